// File: doc/BRIEF.md
# Chroma Pair Expander

This block takes pixels from a registered input port and turns them into a uniform 24-bit stream of three 8-bit lanes. A qualifier input marks active video. In packed 4:2:2 mode, each pixel carries a luma byte plus one chroma byte, and the chroma byte alternates between blue-difference and red-difference. The block tracks which of the two each pixel holds, counting from the start of active video. It gives every pixel of a pair the same blue-difference and red-difference values by repeating them. In full 4:4:4 mode, and for green/blue/red data, the three lanes pass through unchanged.

Two optional steps follow. The first inverts the top bit of the two chroma lanes, which turns offset-binary chroma into two's complement. The second is an AND mask with one bit per output bit, held in a register that can be written. The output carries a valid flag and is forced to zero outside active video. The latency is the same in every mode.

Top module: `yc422_formatter`

## Requirements
- R1: While reset is asserted, `pix_o` is zero and `vld_o` is low. Reset sets the mask register to all ones.
- R2: A pixel captured at rising edge k appears on `pix_o` after rising edge k+2. `vld_o` after edge k+2 equals `av_i` as captured at edge k.
- R3: When `vld_o` is low, `pix_o` is zero.
- R4: With `fmt422_i`=1, the input layout is luma in bits 15..8 and chroma in bits 7..0. The output layout is luma in bits 23..16, blue-difference in bits 15..8 and red-difference in bits 7..0. Each pixel's own luma reaches bits 23..16.
- R5: The first pixel captured with `av_i` high after a cycle with `av_i` low is a blue-difference sample. After that, the phase alternates on every pixel. The phase restarts on every rising edge of `av_i`, even when the previous run held an odd number of pixels.
- R6: Both pixels of a pair carry identical chroma lanes. These are the blue-difference byte of the first pixel and the red-difference byte of the second pixel.
- R7: A blue-difference pixel that ends an active run has no partner. It uses 0x80 as its raw red-difference value.
- R8: With `twos_en_i`=1, bits 15 and 7 of the formatted output are inverted. Bits 23..16 are never changed. With `twos_en_i`=0, no bit is inverted.
- R9: With `fmt422_i`=0, the 24 input bits pass through to the output in place.
- R10: Each output is ANDed with the mask register's value as it stood before the output edge. A write through `mask_we_i`/`mask_d_i` at edge k affects outputs from edge k+1 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 24 | Input pixel word |
| av_i | input | 1 | Active-video qualifier |
| fmt422_i | input | 1 | 1: packed 4:2:2 input, 0: 24-bit pass-through |
| twos_en_i | input | 1 | Enable inversion of the top bit in the chroma lanes |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_d_i | input | 24 | Mask register write data |
| pix_o | output | 24 | Formatted, masked pixel |
| vld_o | output | 1 | Output valid |

## Verification
A wrong phase bit shows up on the first pair of a run. It appears as swapped or stale chroma lanes two edges after the pixel was captured, and it most often follows an odd-length line. A stale hold register for the blue-difference byte corrupts only the second pixel of each pair. A mask or inversion fault appears in the first valid output after the setting changes. The reference model rebuilds each expected output from the recorded input history and the run position, so any of these faults produces a mismatch in the cycle where it first appears.

// File: rtl/yc_fmt_pkg.sv
package yc_fmt_pkg;
  typedef enum logic {PH_CB = 1'b0, PH_CR = 1'b1} phase_e;
  localparam int unsigned LANES = 3;
endpackage

// File: rtl/fmt_capture.sv
module fmt_capture
  import yc_fmt_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned PW = LANES * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pix_i,
  input  logic          av_i,
  output logic [PW-1:0] s1_pix_o,
  output logic          s1_av_o,
  output phase_e        s1_ph_o
);
  // set when the next active pixel is a red-difference sample
  logic nxt_cr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_pix_o <= '0;
      s1_av_o  <= 1'b0;
      s1_ph_o  <= PH_CB;
      nxt_cr_q <= 1'b0;
    end else begin
      s1_pix_o <= pix_i;
      s1_av_o  <= av_i;
      s1_ph_o  <= (av_i && nxt_cr_q) ? PH_CR : PH_CB;
      nxt_cr_q <= av_i && !nxt_cr_q;
    end
  end
endmodule

// File: rtl/fmt_rebuild.sv
module fmt_rebuild
  import yc_fmt_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned PW = LANES * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] s1_pix_i,
  input  logic          s1_av_i,
  input  phase_e        s1_ph_i,
  input  logic          fmt422_i,
  output logic [PW-1:0] raw_o,
  output logic          raw_av_o
);
  localparam logic [BW-1:0] NEUTRAL = BW'(1) << (BW - 1);

  logic [PW-1:0] s2_pix_q;
  logic          s2_av_q;
  phase_e        s2_ph_q;
  logic [BW-1:0] cb_hold_q;
  logic [BW-1:0] y_w, c_w, cb_w, cr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_pix_q  <= '0;
      s2_av_q   <= 1'b0;
      s2_ph_q   <= PH_CB;
      cb_hold_q <= '0;
    end else begin
      s2_pix_q <= s1_pix_i;
      s2_av_q  <= s1_av_i;
      s2_ph_q  <= s1_ph_i;
      if (s2_av_q && s2_ph_q == PH_CB) cb_hold_q <= s2_pix_q[BW-1:0];
    end
  end

  assign y_w = s2_pix_q[2*BW-1:BW];
  assign c_w = s2_pix_q[BW-1:0];

  always_comb begin
    if (s2_ph_q == PH_CB) begin
      cb_w = c_w;
      // look ahead one stage for the partner sample
      cr_w = (s1_av_i && s1_ph_i == PH_CR) ? s1_pix_i[BW-1:0] : NEUTRAL;
    end else begin
      cb_w = cb_hold_q;
      cr_w = c_w;
    end
  end

  assign raw_o    = fmt422_i ? {y_w, cb_w, cr_w} : s2_pix_q;
  assign raw_av_o = s2_av_q;
endmodule

// File: rtl/fmt_output.sv
module fmt_output
  import yc_fmt_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned PW = LANES * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] raw_i,
  input  logic          av_i,
  input  logic          twos_en_i,
  input  logic          mask_we_i,
  input  logic [PW-1:0] mask_d_i,
  output logic [PW-1:0] mask_o,
  output logic [PW-1:0] pix_o,
  output logic          vld_o
);
  logic [PW-1:0] conv_w;

  // lanes 0 and 1 hold chroma; lane 2 holds luma
  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    if (g < 2) begin : g_chroma
      assign conv_w[g*BW +: BW] = raw_i[g*BW +: BW] ^ {twos_en_i, {(BW-1){1'b0}}};
    end else begin : g_luma
      assign conv_w[g*BW +: BW] = raw_i[g*BW +: BW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      pix_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_o <= mask_d_i;
      vld_o <= av_i;
      pix_o <= av_i ? (conv_w & mask_o) : '0;
    end
  end
endmodule

// File: rtl/yc422_formatter.sv
module yc422_formatter
  import yc_fmt_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned PW = LANES * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pix_i,
  input  logic          av_i,
  input  logic          fmt422_i,
  input  logic          twos_en_i,
  input  logic          mask_we_i,
  input  logic [PW-1:0] mask_d_i,
  output logic [PW-1:0] pix_o,
  output logic          vld_o
);
  logic [PW-1:0] s1_pix, raw, mask_q;
  logic          s1_av, raw_av;
  phase_e        s1_ph;

  fmt_capture #(.BW(BW)) u_cap (
    .clk_i, .rst_ni, .pix_i, .av_i,
    .s1_pix_o(s1_pix), .s1_av_o(s1_av), .s1_ph_o(s1_ph)
  );

  fmt_rebuild #(.BW(BW)) u_reb (
    .clk_i, .rst_ni,
    .s1_pix_i(s1_pix), .s1_av_i(s1_av), .s1_ph_i(s1_ph),
    .fmt422_i, .raw_o(raw), .raw_av_o(raw_av)
  );

  fmt_output #(.BW(BW)) u_out (
    .clk_i, .rst_ni, .raw_i(raw), .av_i(raw_av), .twos_en_i,
    .mask_we_i, .mask_d_i, .mask_o(mask_q), .pix_o, .vld_o
  );
endmodule

// File: rtl/yc_fmt_chk.sv
module yc_fmt_chk #(
  parameter int unsigned BW = 8,
  localparam int unsigned PW = 3 * BW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] pix_i,
  input logic          av_i,
  input logic          fmt422_i,
  input logic          twos_en_i,
  input logic [PW-1:0] mask_q,
  input logic [PW-1:0] pix_o,
  input logic          vld_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> pix_o == '0);

  p_vld_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q == 2'd3 |-> vld_o == $past(av_i, 3));

  p_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q != 2'd0 |-> (pix_o & ~$past(mask_q)) == '0);

  p_y_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && vld_o && $past(fmt422_i) && $past(mask_q[PW-1:2*BW]) == '1)
      |-> pix_o[PW-1:2*BW] == $past(pix_i[2*BW-1:BW], 3));

  p_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && vld_o && !$past(fmt422_i) && $past(mask_q) == '1)
      |-> pix_o[PW-1:2*BW] == $past(pix_i[PW-1:2*BW], 3));

  p_first_cb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && $rose(vld_o) && $past(fmt422_i) && !$past(twos_en_i)
     && $past(mask_q) == '1)
      |-> pix_o[2*BW-1:BW] == $past(pix_i[BW-1:0], 3));
endmodule

bind yc422_formatter yc_fmt_chk #(.BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .av_i(av_i),
  .fmt422_i(fmt422_i), .twos_en_i(twos_en_i), .mask_q(mask_q),
  .pix_o(pix_o), .vld_o(vld_o)
);

// File: tb/sim_yc422_formatter.sv
module sim_yc422_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] pix_i = '0;
  logic        av_i = 1'b0;
  logic        fmt422_i = 1'b0;
  logic        twos_en_i = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [23:0] mask_d_i = '0;
  logic [23:0] pix_o;
  logic        vld_o;

  yc422_formatter u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R9";
  logic [23:0] rec_pix [DEPTH];
  logic        rec_av [DEPTH];
  logic        rec_fmt [DEPTH];
  logic        rec_twos [DEPTH];
  logic [23:0] rec_mask [DEPTH];
  int          rec_idx [DEPTH];
  int          ecnt = 0;
  logic [23:0] mmodel = 24'hFFFFFF;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 0;

  // record every edge after reset release
  always @(posedge clk_i) begin
    if (rst_ni && ecnt < DEPTH) begin
      rec_pix[ecnt]  = pix_i;
      rec_av[ecnt]   = av_i;
      rec_fmt[ecnt]  = fmt422_i;
      rec_twos[ecnt] = twos_en_i;
      rec_mask[ecnt] = mmodel;
      if (!av_i) rec_idx[ecnt] = 0;
      else if (ecnt > 0 && rec_av[ecnt-1]) rec_idx[ecnt] = rec_idx[ecnt-1] + 1;
      else rec_idx[ecnt] = 0;
      if (mask_we_i) mmodel = mask_d_i;
      ecnt++;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  // compare against the reference after every edge
  always @(negedge clk_i) begin
    if (rst_ni && ecnt > 0 && !done) begin
      int e, n;
      logic [23:0] exp_p;
      logic        exp_v;
      logic [7:0]  y, cb, cr;
      e = ecnt - 1;
      n = e - 2;
      exp_p = '0;
      exp_v = 1'b0;
      if (n >= 0 && rec_av[n]) begin
        exp_v = 1'b1;
        if (rec_fmt[e]) begin
          y = rec_pix[n][15:8];
          if (rec_idx[n] % 2 == 0) begin
            cb = rec_pix[n][7:0];
            cr = (rec_av[n+1] && rec_idx[n+1] % 2 == 1) ? rec_pix[n+1][7:0] : 8'h80;
          end else begin
            cb = rec_pix[n-1][7:0];
            cr = rec_pix[n][7:0];
          end
          exp_p = {y, cb, cr};
        end else exp_p = rec_pix[n];
        if (rec_twos[e]) exp_p = exp_p ^ 24'h008080;
        exp_p = exp_p & rec_mask[e];
      end
      check("R2", {23'd0, vld_o}, {23'd0, exp_v});
      check(exp_v ? cur_req : "R3", pix_o, exp_p);
    end
  end

  function automatic logic [23:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:8];
  endfunction

  task automatic idle(input int k);
    repeat (k) begin
      @(negedge clk_i);
      av_i = 1'b0;
      pix_i = next_rand();
    end
  endtask

  task automatic line(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      av_i = 1'b1;
      pix_i = next_rand();
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", pix_o, 24'h0);
    check("R1", {23'd0, vld_o}, 24'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(3);
    // R9 and R1 default mask: 444 pass-through
    cur_req = "R9";
    line(8); idle(4);
    // R4, R6: even 422 line
    fmt422_i = 1'b1;
    cur_req = "R6";
    line(10); idle(3);
    cur_req = "R4";
    line(4); idle(3);
    // R5, R7: odd line, single-cycle gap, phase restart
    cur_req = "R7";
    line(7); idle(1);
    cur_req = "R5";
    line(6); idle(1);
    line(3); idle(1);
    line(1); idle(4);
    // R8: inversion in both modes
    twos_en_i = 1'b1;
    cur_req = "R8";
    line(8); idle(3);
    fmt422_i = 1'b0;
    line(5); idle(3);
    twos_en_i = 1'b0;
    fmt422_i = 1'b1;
    line(4); idle(3);
    // R10: mask writes during idle and inside a line
    cur_req = "R10";
    @(negedge clk_i);
    mask_we_i = 1'b1; mask_d_i = 24'hF00F3C;
    @(negedge clk_i);
    mask_we_i = 1'b0;
    line(6);
    @(negedge clk_i);
    av_i = 1'b1; pix_i = next_rand();
    mask_we_i = 1'b1; mask_d_i = 24'h5AA5C3;
    @(negedge clk_i);
    mask_we_i = 1'b0;
    av_i = 1'b1; pix_i = next_rand();
    line(5); idle(4);
    twos_en_i = 1'b1;
    line(5); idle(4);
    finish_run();
  end
endmodule